// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides the RF clock of a frequency synthesizer by a programmable integer N and hands one pulse per N input cycles to the phase detector. A dual-modulus prescaler counts by P or P+1 input cycles. A swallow count A and a main count B set how many prescaler cycles of each kind make up one output period, so N = B·P + A. The modulus control between the two counters stays inside the block. The whole divider runs synchronously on the RF clock, so it can be modelled and verified as ordinary digital logic.

A controller holds three named states. HOLD keeps every counter at its load value while a counter-reset or power-down request is present. SWALLOW drives the modulus control high, so each prescaler cycle lasts P+1. MAIN drives it low, so each prescaler cycle lasts P. The transitions are:
- *release*: HOLD to SWALLOW when the loaded A is non-zero, or to MAIN when it is zero.
- *swallow-done*: SWALLOW to MAIN after the last swallow cycle.
- *reload*: SWALLOW or MAIN back to SWALLOW or MAIN at the end of the B-th prescaler cycle. This is where the output pulse fires and new settings are taken.
- *hold*: any state to HOLD while counter reset or power-down is asserted.

Top module: `pswallow_div`

## Requirements
- R1: With the select code s (0, 1, 2, 3 giving P = 8, 16, 32, 64) and 3 ≤ B, A ≤ B, one output pulse occurs every N = B·P + A rising edges of `clk`.
- R2: After release from hold or reset, the first output pulse is visible right after the N-th rising edge, counting the first edge at which no hold is present as edge 1.
- R3: Each output pulse is high for exactly one clock cycle.
- R4: Within a period, the first A prescaler cycles last P+1 input cycles and the remaining B−A last P cycles. This holds also for A = B and for the larger prescaler ratios.
- R5: A main count B below 3 is treated as 3.
- R6: When A exceeds B, every prescaler cycle of the period uses P+1, giving N = B·(P+1).
- R7: While `ctr_rst` is high, no pulse is produced and the counters stay at their load values. Counting restarts aligned to the release edge.
- R8: `pwr_dn` has the same holding effect as `ctr_rst`. Settings applied during the hold are used from the release onward.
- R9: Changes to A, B or the select code made in the middle of a period leave that period's length unchanged. They take effect from the next period.
- R10: While the asynchronous `rst_n` is low, `pd_pulse` is low. After `rst_n` is released, counting starts from the load state as in R2.
- R11: With A = 0, every prescaler cycle uses P, so N = B·P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided RF input clock that the divider counts |
| rst_n | input | 1 | Asynchronous active-low reset |
| p_sel | input | 2 | Prescaler select: P = 8 << p_sel |
| a_val | input | 6 | Swallow count A |
| b_val | input | 13 | Main count B (values below 3 act as 3) |
| ctr_rst | input | 1 | Holds the counters at load state while high |
| pwr_dn | input | 1 | Power-down: same hold on the counters |
| pd_pulse | output | 1 | One-cycle pulse per N input cycles, to the phase detector |

## Verification
The main stimulus is an exhaustive sweep of A and B from 0 to 9 at P = 8. Because N is measured as the spacing of two consecutive pulses after a release, the sweep tells the normal B·P + A case apart from the clamped small-B case, the A > B case and the A = 0 case. Spot settings at P = 16, 32 and 64, including A = B and A = 63, separate the four prescaler ratios. A mid-period change of settings tells whether the new values take effect at the reload point or earlier. A power-down applied during counting, with new settings loaded during the hold, shows whether the hold suppresses pulses and whether it realigns the count to the release edge.

// File: rtl/psd_pkg.sv
package psd_pkg;

    // Controller states of the divider
    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2
    } psd_state_e;

endpackage

// File: rtl/psd_cfg.sv
module psd_cfg #(
    parameter int A_W   = 6,
    parameter int B_W   = 13,
    parameter int SEL_W = 2,
    parameter int B_MIN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEL_W-1:0] sel_in,
    input  logic [A_W-1:0]   a_in,
    input  logic [B_W-1:0]   b_in,
    output logic [A_W-1:0]   next_a,
    output logic [B_W-1:0]   next_b,
    output logic [SEL_W-1:0] cfg_sel
);

    localparam logic [B_W-1:0] B_FLOOR = B_W'(B_MIN);

    // Values the counters take at the next load point (B clamped, R5)
    always_comb begin
        next_a = a_in;
        next_b = (b_in < B_FLOOR) ? B_FLOOR : b_in;
    end

    // Prescaler select is frozen between load points (R9)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_sel <= '0;
        end else if (load) begin
            cfg_sel <= sel_in;
        end
    end

endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
    parameter int SEL_W      = 2,
    parameter int P_MIN_LOG2 = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [SEL_W-1:0] sel,
    input  logic             mod_ctl,
    output logic             tick
);

    localparam int SEL_MAX = (1 << SEL_W) - 1;
    localparam int PC_W    = P_MIN_LOG2 + SEL_MAX + 1;

    logic [PC_W-1:0] cnt_q;
    logic [PC_W-1:0] p_val;
    logic [PC_W-1:0] last_val;

    // Lower modulus P = 2^(P_MIN_LOG2 + sel); the cycle lasts P + mod_ctl
    always_comb begin
        p_val    = PC_W'(1) << (P_MIN_LOG2 + int'(sel));
        last_val = p_val - PC_W'(1) + {{(PC_W-1){1'b0}}, mod_ctl};
        tick     = !hold && (cnt_q == last_val);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (hold || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PC_W'(1);
        end
    end

    // R1: the phase counter never passes the longer modulus
    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= p_val);

    // R4: a completed prescaler cycle restarts from zero
    p_tick_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));

endmodule

// File: rtl/psd_ctrl.sv
module psd_ctrl
    import psd_pkg::*;
#(
    parameter int A_W = 6,
    parameter int B_W = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hold,
    input  logic           tick,
    input  logic [A_W-1:0] next_a,
    input  logic [B_W-1:0] next_b,
    output logic           mod_ctl,
    output logic           load_cfg,
    output logic           pulse
);

    psd_state_e     st_q, st_n;
    logic [A_W-1:0] a_q, a_n;
    logic [B_W-1:0] b_q, b_n;
    logic           pulse_n;
    logic           reload;

    // Next-state and counter logic
    always_comb begin
        st_n    = st_q;
        a_n     = a_q;
        b_n     = b_q;
        pulse_n = 1'b0;
        reload  = 1'b0;
        if (hold) begin
            // hold: any state to HOLD, counters at load value (R7, R8)
            st_n = ST_HOLD;
            a_n  = next_a;
            b_n  = next_b;
        end else begin
            unique case (st_q)
                ST_HOLD: begin
                    // release
                    reload = 1'b1;
                end
                ST_SWALLOW: begin
                    if (tick) begin
                        if (b_q == B_W'(1)) begin
                            reload  = 1'b1;
                            pulse_n = 1'b1;
                        end else begin
                            b_n = b_q - B_W'(1);
                            a_n = a_q - A_W'(1);
                            if (a_q == A_W'(1)) begin
                                st_n = ST_MAIN; // swallow-done
                            end
                        end
                    end
                end
                ST_MAIN: begin
                    if (tick) begin
                        if (b_q == B_W'(1)) begin
                            reload  = 1'b1;
                            pulse_n = 1'b1;
                        end else begin
                            b_n = b_q - B_W'(1);
                        end
                    end
                end
                default: begin
                    st_n = ST_HOLD;
                end
            endcase
            if (reload) begin
                a_n  = next_a;
                b_n  = next_b;
                st_n = (next_a != '0) ? ST_SWALLOW : ST_MAIN;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_HOLD;
            a_q   <= '0;
            b_q   <= B_W'(1);
            pulse <= 1'b0;
        end else begin
            st_q  <= st_n;
            a_q   <= a_n;
            b_q   <= b_n;
            pulse <= pulse_n;
        end
    end

    // Outputs
    always_comb begin
        mod_ctl  = (st_q == ST_SWALLOW);
        load_cfg = hold || reload;
    end

    // R3: the output pulse never lasts two cycles
    p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

    // R7 (and R8): a hold request silences the output and parks the FSM
    p_hold_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (!pulse && st_q == ST_HOLD));

    // R4: the swallow phase only runs while swallow credit remains
    p_swallow_credit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SWALLOW) |-> (a_q != '0));

    // R4: modulus control changes only at a prescaler cycle boundary
    p_modctl_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_HOLD && !hold && !tick) |=> $stable(mod_ctl));

    // R1: the main count never underflows while counting
    p_bcount_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_HOLD) |-> (b_q != '0));

endmodule

// File: rtl/pswallow_div.sv
module pswallow_div #(
    parameter int A_W        = 6,
    parameter int B_W        = 13,
    parameter int SEL_W      = 2,
    parameter int P_MIN_LOG2 = 3,
    parameter int B_MIN      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] p_sel,
    input  logic [A_W-1:0]   a_val,
    input  logic [B_W-1:0]   b_val,
    input  logic             ctr_rst,
    input  logic             pwr_dn,
    output logic             pd_pulse
);

    logic             hold;
    logic             tick;
    logic             mod_ctl;
    logic             load_cfg;
    logic [A_W-1:0]   next_a;
    logic [B_W-1:0]   next_b;
    logic [SEL_W-1:0] cfg_sel;

    assign hold = ctr_rst | pwr_dn;

    psd_cfg #(
        .A_W  (A_W),
        .B_W  (B_W),
        .SEL_W(SEL_W),
        .B_MIN(B_MIN)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load_cfg),
        .sel_in (p_sel),
        .a_in   (a_val),
        .b_in   (b_val),
        .next_a (next_a),
        .next_b (next_b),
        .cfg_sel(cfg_sel)
    );

    psd_prescaler #(
        .SEL_W     (SEL_W),
        .P_MIN_LOG2(P_MIN_LOG2)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (hold),
        .sel    (cfg_sel),
        .mod_ctl(mod_ctl),
        .tick   (tick)
    );

    psd_ctrl #(
        .A_W(A_W),
        .B_W(B_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold),
        .tick    (tick),
        .next_a  (next_a),
        .next_b  (next_b),
        .mod_ctl (mod_ctl),
        .load_cfg(load_cfg),
        .pulse   (pd_pulse)
    );

    // R10: reset leaves the output low on the first edge after it
    p_reset_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !pd_pulse);

endmodule

// File: tb/pswallow_div_tb.sv
`timescale 1ns/1ps
module pswallow_div_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  p_sel = 2'd0;
    logic [5:0]  a_val = 6'd1;
    logic [12:0] b_val = 13'd3;
    logic        ctr_rst = 1'b0;
    logic        pwr_dn = 1'b0;
    logic        pd_pulse;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    pswallow_div u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .p_sel   (p_sel),
        .a_val   (a_val),
        .b_val   (b_val),
        .ctr_rst (ctr_rst),
        .pwr_dn  (pwr_dn),
        .pd_pulse(pd_pulse)
    );

    function automatic int exp_n(input int sel, input int a, input int b);
        int p  = 8 << sel;
        int bb = (b < 3) ? 3 : b;
        if (a > bb) return bb * (p + 1);
        return bb * p + a;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Counts negedges from a release; edge k's effect is seen at negedge k
    task automatic measure(input int n, input string tag);
        int  first = 0;
        int  second = 0;
        int  k = 0;
        bit  prev = 1'b0;
        bit  wide = 1'b0;
        while (second == 0 && k < 3 * n + 20) begin
            @(negedge clk);
            k++;
            if (pd_pulse) begin
                if (first == 0) first = k;
                else if (second == 0) second = k;
                if (prev) wide = 1'b1;
            end
            prev = pd_pulse;
        end
        check(first == n, {"R2/", tag}, first, n);
        check(second == 2 * n, tag, second, 2 * n);
        @(negedge clk);
        check(!wide && !pd_pulse, "R3", int'(wide), 0);
    endtask

    task automatic run_cfg(input int sel, input int a, input int b, input string tag);
        @(negedge clk);
        ctr_rst = 1'b1;
        p_sel = 2'(sel);
        a_val = 6'(a);
        b_val = 13'(b);
        @(negedge clk);
        check(!pd_pulse, "R7", int'(pd_pulse), 0);
        @(negedge clk);
        ctr_rst = 1'b0;
        measure(exp_n(sel, a, b), tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        // R10: reset state, then counting from load state
        repeat (3) @(negedge clk);
        check(!pd_pulse, "R10", int'(pd_pulse), 0);
        rst_n = 1'b1;
        measure(exp_n(0, 1, 3), "R10");

        // Exhaustive sweep at P = 8
        for (int a = 0; a < 10; a++) begin
            for (int b = 0; b < 10; b++) begin
                string tag;
                if (b < 3) tag = "R5";
                else if (a > b) tag = "R6";
                else if (a == 0) tag = "R11";
                else tag = "R1";
                run_cfg(0, a, b, tag);
            end
        end

        // Larger prescaler ratios and swallow edge cases
        run_cfg(1, 15, 15, "R4");
        run_cfg(1, 0, 20, "R11");
        run_cfg(2, 31, 40, "R4");
        run_cfg(3, 5, 70, "R1");
        run_cfg(3, 63, 63, "R4");

        // R9: mid-period change takes effect at next period only
        begin
            int n1 = exp_n(0, 2, 5);
            int n2 = exp_n(0, 7, 9);
            int k = 0;
            int pulses[3];
            int idx = 0;
            @(negedge clk);
            ctr_rst = 1'b1; p_sel = 2'd0; a_val = 6'd2; b_val = 13'd5;
            @(negedge clk);
            ctr_rst = 1'b0;
            while (idx < 3 && k < 400) begin
                @(negedge clk);
                k++;
                if (pd_pulse) begin pulses[idx] = k; idx++; end
                if (k == n1 + 10) begin a_val = 6'd7; b_val = 13'd9; end
            end
            check(pulses[0] == n1, "R9", pulses[0], n1);
            check(pulses[1] == 2 * n1, "R9", pulses[1], 2 * n1);
            check(pulses[2] == 2 * n1 + n2, "R9", pulses[2], 2 * n1 + n2);
        end

        // R8: power-down mid-count, new settings during hold
        begin
            bit seen = 1'b0;
            @(negedge clk);
            ctr_rst = 1'b1; p_sel = 2'd0; a_val = 6'd3; b_val = 13'd4;
            @(negedge clk);
            ctr_rst = 1'b0;
            repeat (20) @(negedge clk);
            pwr_dn = 1'b1;
            a_val = 6'd1; b_val = 13'd3;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (pd_pulse) seen = 1'b1;
            end
            check(!seen, "R8", int'(seen), 0);
            pwr_dn = 1'b0;
            measure(exp_n(0, 1, 3), "R8");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule